// File: doc/BRIEF.md
# In-Order Retirement Reorder Buffer

This block is the circular reorder buffer of an out-of-order core. Renamed micro-ops enter it in program order, up to three in a cycle, and each receives an entry tag. Execution results come back out of order through a writeback port. The writeback carries a tag, a result value and two fault flags: exception and mispredict. The buffer retires finished entries strictly from the oldest one onward, up to three in a cycle. Retirement copies each result into an eight-entry architectural register file and releases the entry's rename mapping.

The block keeps its own rename table. For each architectural register the table records the tag of the newest in-flight producer. A retiring entry clears that record, and reports the clear on the clear port, only when the record still names the retiring entry. A fault at the oldest entry halts retirement and is reported with the entry's tag. One cycle later the whole window is discarded.

Top module: `rob_core`

## Requirements
- R1: After reset, occupancy is 0, no rename mapping is valid, every architectural register reads 0, lane 0 of `alloc_tag` reads 0, and `ret_valid`, `clr_valid` and `fault_valid` are 0.
- R2: `alloc_tag` lane i shows the tail index plus i, wrapping from 39 back to 0. `alloc_ok` is 1 when `alloc_num` is no larger than the free entries (40 minus occupancy) and no fault is reported. When `alloc_ok` is 1, the lowest `alloc_num` lanes take those tags at the clock edge.
- R3: A request for more entries than are free is refused as a whole (`alloc_ok`=0). No entry is taken, and occupancy never exceeds 40.
- R4: A writeback to an occupied tag stores the data and flags and marks the entry done. A writeback to a tag that is not occupied has no effect: an entry allocated at that tag later is still not done.
- R5: In the cycle after the edge at which the oldest entries are done without faults, lanes 0..2 of the retire port show them, oldest in lane 0. At most three retire in a cycle. An entry retires only when every older entry retires in the same cycle or earlier.
- R6: A retiring entry whose write-enable is set writes its data to its destination register at that edge. When several entries in one group write the same register, the youngest value is kept.
- R7: An allocated lane with write-enable sets the mapping of its destination to its tag, and the highest lane wins. A retiring entry clears the mapping, and raises `clr_valid` for its lane, only if the mapping still names its tag and no lane allocated in the same cycle writes that register.
- R8: When the oldest occupied entry is done with exception or mispredict set, `fault_valid` is 1, `fault_tag` is its index, and `fault_mispred` is its mispredict flag. In that cycle nothing retires and allocation is refused. At the next edge the buffer empties: occupancy becomes 0, the tag count restarts at 0 and all mappings become invalid. The faulting entry's result never reaches the register file.
- R9: An entry allocated with write-enable clear sets no mapping. When it retires it changes no architectural register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_num | input | 2 | Number of micro-ops requested this cycle (0..3) |
| alloc_dst | input | 9 | Destination register per lane, 3 bits each, lane 0 in the low bits |
| alloc_wen | input | 3 | Register write-enable per lane |
| alloc_ok | output | 1 | Request fits and is accepted |
| alloc_tag | output | 18 | Tag offered to each lane, 6 bits each |
| wb_valid | input | 1 | Writeback present |
| wb_tag | input | 6 | Entry being completed |
| wb_data | input | 32 | Result value |
| wb_exc | input | 1 | Completed with exception |
| wb_mispred | input | 1 | Completed as mispredicted branch |
| ret_valid | output | 3 | Lane retires this cycle |
| ret_tag | output | 18 | Tag per retiring lane |
| ret_reg | output | 9 | Destination register per retiring lane |
| ret_data | output | 96 | Result per retiring lane |
| clr_valid | output | 3 | Lane clears the rename mapping of its register |
| clr_reg | output | 9 | Register whose mapping a lane clears |
| fault_valid | output | 1 | Oldest entry faulted; flush at next edge |
| fault_tag | output | 6 | Tag of the faulting entry |
| fault_mispred | output | 1 | Fault is a mispredict (else exception) |
| occupancy | output | 6 | Occupied entries |
| map_valid | output | 8 | Rename mapping valid per register |
| map_tag | output | 48 | Mapped tag per register, 6 bits each |
| arf_data | output | 256 | Architectural register values, 32 bits each |

## Verification
The assertions check four properties on every cycle. Retire lanes always form an unbroken prefix starting at lane 0. A reported fault blocks retirement and leaves the buffer empty one edge later. A refused request never raises occupancy. A cleared mapping and the youngest register write are actually visible after the edge. Only the bench scenarios can show the rest: the tag order across the wrap at 40, refusal when the buffer is full, retirement that waits for the oldest of several out-of-order writebacks, a younger writer keeping its mapping, and the register file contents after a flush.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // circular index arithmetic shared by allocation, retirement and flush
  function automatic int unsigned wrap_add(int unsigned ptr, int unsigned n, int unsigned depth);
    int unsigned s;
    s = ptr + n;
    return (s >= depth) ? s - depth : s;
  endfunction

  function automatic int unsigned free_slots(int unsigned occ, int unsigned depth);
    return depth - occ;
  endfunction
endpackage

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
  import rob_pkg::*;
#(
  parameter int DEPTH = 40,
  parameter int LANES = 3,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IDX_W-1:0]       head,
  input  logic [CNT_W-1:0]       occ,
  input  logic [DEPTH-1:0]       done,
  input  logic [DEPTH-1:0]       bad,
  output logic [LANES-1:0]       lane_go,
  output logic [LANES*IDX_W-1:0] lane_idx,
  output logic                   head_bad
);
  logic [IDX_W-1:0] idx_a [LANES];
  logic             chain;

  always_comb begin
    chain = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      idx_a[i] = IDX_W'(wrap_add(32'(head), i, DEPTH));
      chain = chain && (CNT_W'(i) < occ) && done[idx_a[i]] && !bad[idx_a[i]];
      lane_go[i] = chain;
      lane_idx[i*IDX_W +: IDX_W] = idx_a[i];
    end
  end

  assign head_bad = (occ != '0) && done[head] && bad[head];

  // R5: retiring lanes are a contiguous run starting at lane 0
  assert_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0((LANES+1)'({1'b0, lane_go}) + (LANES+1)'(1)));
endmodule

// File: rtl/rob_rat.sv
module rob_rat #(
  parameter int NREG  = 8,
  parameter int LANES = 3,
  parameter int TAG_W = 6,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [LANES-1:0]       alloc_we,
  input  logic [LANES*REG_W-1:0] alloc_reg,
  input  logic [LANES*TAG_W-1:0] alloc_tag,
  input  logic [LANES-1:0]       ret_we,
  input  logic [LANES*REG_W-1:0] ret_reg,
  input  logic [LANES*TAG_W-1:0] ret_tag,
  output logic [LANES-1:0]       clr_valid,
  output logic [NREG-1:0]        map_valid,
  output logic [NREG*TAG_W-1:0]  map_tag
);
  logic [NREG-1:0]  valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [NREG];
  logic [TAG_W-1:0] tag_d [NREG];
  logic [REG_W-1:0] ret_reg_a [LANES];
  logic [REG_W-1:0] alc_reg_a [LANES];
  logic             shadowed;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      ret_reg_a[i] = ret_reg[i*REG_W +: REG_W];
      alc_reg_a[i] = alloc_reg[i*REG_W +: REG_W];
    end
  end

  // a clear is valid only if the mapping still names the retiring tag
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      shadowed = 1'b0;
      for (int j = 0; j < LANES; j++)
        if (alloc_we[j] && alc_reg_a[j] == ret_reg_a[i]) shadowed = 1'b1;
      clr_valid[i] = ret_we[i] && valid_q[ret_reg_a[i]] &&
                     (tag_q[ret_reg_a[i]] == ret_tag[i*TAG_W +: TAG_W]) && !shadowed;
    end
  end

  always_comb begin
    valid_d = valid_q;
    for (int r = 0; r < NREG; r++) tag_d[r] = tag_q[r];
    for (int i = 0; i < LANES; i++)
      if (clr_valid[i]) valid_d[ret_reg_a[i]] = 1'b0;
    for (int j = 0; j < LANES; j++)
      if (alloc_we[j]) begin
        valid_d[alc_reg_a[j]] = 1'b1;
        tag_d[alc_reg_a[j]]   = alloc_tag[j*TAG_W +: TAG_W];
      end
    if (flush) valid_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
    for (int r = 0; r < NREG; r++) tag_q[r] <= rst_n ? tag_d[r] : '0;
  end

  assign map_valid = valid_q;
  for (genvar r = 0; r < NREG; r++) begin : g_out
    assign map_tag[r*TAG_W +: TAG_W] = tag_q[r];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R7: a reported clear leaves the register unmapped after the edge
    assert_clear_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_valid[g] |=> !map_valid[$past(ret_reg_a[g])]);
  end
endmodule

// File: rtl/rob_arf.sv
module rob_arf #(
  parameter int NREG   = 8,
  parameter int LANES  = 3,
  parameter int DATA_W = 32,
  parameter int REG_W  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        we,
  input  logic [LANES*REG_W-1:0]  wreg,
  input  logic [LANES*DATA_W-1:0] wdata,
  output logic [NREG*DATA_W-1:0]  regs
);
  logic [DATA_W-1:0] q [NREG];
  logic [DATA_W-1:0] d [NREG];

  // later lanes are younger, so they overwrite earlier ones
  always_comb begin
    for (int r = 0; r < NREG; r++) d[r] = q[r];
    for (int i = 0; i < LANES; i++)
      if (we[i]) d[wreg[i*REG_W +: REG_W]] = wdata[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) q[r] <= rst_n ? d[r] : '0;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_out
    assign regs[r*DATA_W +: DATA_W] = q[r];
  end

  // R6: the youngest lane's write is the value left behind
  assert_youngest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we[LANES-1] |=> regs[$past(wreg[(LANES-1)*REG_W +: REG_W])*DATA_W +: DATA_W]
                    == $past(wdata[(LANES-1)*DATA_W +: DATA_W]));
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH  = 40,
  parameter int LANES  = 3,
  parameter int DATA_W = 32,
  parameter int NREG   = 8,
  parameter int TAG_W  = $clog2(DEPTH),
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int REG_W  = $clog2(NREG),
  parameter int NUM_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_W-1:0]        alloc_num,
  input  logic [LANES*REG_W-1:0]  alloc_dst,
  input  logic [LANES-1:0]        alloc_wen,
  output logic                    alloc_ok,
  output logic [LANES*TAG_W-1:0]  alloc_tag,
  input  logic                    wb_valid,
  input  logic [TAG_W-1:0]        wb_tag,
  input  logic [DATA_W-1:0]       wb_data,
  input  logic                    wb_exc,
  input  logic                    wb_mispred,
  output logic [LANES-1:0]        ret_valid,
  output logic [LANES*TAG_W-1:0]  ret_tag,
  output logic [LANES*REG_W-1:0]  ret_reg,
  output logic [LANES*DATA_W-1:0] ret_data,
  output logic [LANES-1:0]        clr_valid,
  output logic [LANES*REG_W-1:0]  clr_reg,
  output logic                    fault_valid,
  output logic [TAG_W-1:0]        fault_tag,
  output logic                    fault_mispred,
  output logic [CNT_W-1:0]        occupancy,
  output logic [NREG-1:0]         map_valid,
  output logic [NREG*TAG_W-1:0]   map_tag,
  output logic [NREG*DATA_W-1:0]  arf_data
);
  // entry state
  logic [DEPTH-1:0]  e_busy, e_done, e_exc, e_mis, e_wen;
  logic [DATA_W-1:0] e_data [DEPTH];
  logic [REG_W-1:0]  e_dst  [DEPTH];
  logic [TAG_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  occ_q;

  // internal events, named for the assertions
  logic [CNT_W-1:0]  free_cnt;
  logic [NUM_W-1:0]  take_n, ret_cnt;
  logic              wb_in_range, wb_hit;
  logic [LANES-1:0]  lane_alloc, ret_we;
  logic [TAG_W-1:0]  lane_tag [LANES];
  logic [LANES*TAG_W-1:0] ret_idx;
  logic [DEPTH-1:0]  a_hit, r_hit;
  logic [REG_W-1:0]  a_dst [DEPTH];
  logic [DEPTH-1:0]  a_wen;

  rob_retire_sel #(.DEPTH(DEPTH), .LANES(LANES), .IDX_W(TAG_W), .CNT_W(CNT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .head(head_q), .occ(occ_q),
    .done(e_done), .bad(e_exc | e_mis),
    .lane_go(ret_valid), .lane_idx(ret_idx), .head_bad(fault_valid)
  );

  assign fault_tag     = head_q;
  assign fault_mispred = e_mis[head_q];
  assign free_cnt      = CNT_W'(free_slots(32'(occ_q), DEPTH));
  assign alloc_ok      = !fault_valid && (CNT_W'(alloc_num) <= free_cnt);
  assign take_n        = alloc_ok ? alloc_num : '0;
  assign ret_cnt       = NUM_W'($countones(ret_valid));
  assign wb_in_range   = {1'b0, wb_tag} < (TAG_W+1)'(DEPTH);
  assign wb_hit        = wb_valid && !fault_valid && wb_in_range && e_busy[wb_tag];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_tag[i]   = TAG_W'(wrap_add(32'(tail_q), i, DEPTH));
    assign alloc_tag[i*TAG_W +: TAG_W] = lane_tag[i];
    assign lane_alloc[i] = alloc_ok && (NUM_W'(i) < alloc_num);
    assign ret_tag[i*TAG_W +: TAG_W]   = ret_idx[i*TAG_W +: TAG_W];
    assign ret_reg[i*REG_W +: REG_W]   = e_dst[ret_idx[i*TAG_W +: TAG_W]];
    assign ret_data[i*DATA_W +: DATA_W] = e_data[ret_idx[i*TAG_W +: TAG_W]];
    assign ret_we[i]     = ret_valid[i] && e_wen[ret_idx[i*TAG_W +: TAG_W]];
  end
  assign clr_reg = ret_reg;

  // map lanes onto entries
  always_comb begin
    a_hit = '0;
    r_hit = '0;
    a_wen = '0;
    for (int e = 0; e < DEPTH; e++) a_dst[e] = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_alloc[i]) begin
        a_hit[lane_tag[i]] = 1'b1;
        a_dst[lane_tag[i]] = alloc_dst[i*REG_W +: REG_W];
        a_wen[lane_tag[i]] = alloc_wen[i];
      end
      if (ret_valid[i]) r_hit[ret_idx[i*TAG_W +: TAG_W]] = 1'b1;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n || fault_valid) begin
        e_busy[e] <= 1'b0;
        e_done[e] <= 1'b0;
        e_exc[e]  <= 1'b0;
        e_mis[e]  <= 1'b0;
        e_wen[e]  <= 1'b0;
        e_dst[e]  <= '0;
        e_data[e] <= '0;
      end else begin
        if (r_hit[e]) begin
          e_busy[e] <= 1'b0;
          e_done[e] <= 1'b0;
        end
        if (a_hit[e]) begin
          e_busy[e] <= 1'b1;
          e_done[e] <= 1'b0;
          e_exc[e]  <= 1'b0;
          e_mis[e]  <= 1'b0;
          e_wen[e]  <= a_wen[e];
          e_dst[e]  <= a_dst[e];
        end
        if (wb_hit && wb_tag == TAG_W'(e)) begin
          e_done[e] <= 1'b1;
          e_data[e] <= wb_data;
          e_exc[e]  <= wb_exc;
          e_mis[e]  <= wb_mispred;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fault_valid) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      head_q <= TAG_W'(wrap_add(32'(head_q), 32'(ret_cnt), DEPTH));
      tail_q <= TAG_W'(wrap_add(32'(tail_q), 32'(take_n), DEPTH));
      occ_q  <= occ_q - CNT_W'(ret_cnt) + CNT_W'(take_n);
    end
  end
  assign occupancy = occ_q;

  rob_rat #(.NREG(NREG), .LANES(LANES), .TAG_W(TAG_W), .REG_W(REG_W)) u_rat (
    .clk(clk), .rst_n(rst_n), .flush(fault_valid),
    .alloc_we(lane_alloc & alloc_wen), .alloc_reg(alloc_dst), .alloc_tag(alloc_tag),
    .ret_we(ret_we), .ret_reg(ret_reg), .ret_tag(ret_tag),
    .clr_valid(clr_valid), .map_valid(map_valid), .map_tag(map_tag)
  );

  rob_arf #(.NREG(NREG), .LANES(LANES), .DATA_W(DATA_W), .REG_W(REG_W)) u_arf (
    .clk(clk), .rst_n(rst_n), .we(ret_we), .wreg(ret_reg), .wdata(ret_data),
    .regs(arf_data)
  );

  // R3: occupancy stays within the window
  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));
  // R3: a refused request never grows the window
  assert_refuse_no_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_num != '0 && !alloc_ok) |=> occupancy <= $past(occupancy));
  // R8: a fault halts retirement in its cycle
  assert_fault_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> ret_valid == '0);
  // R8: the window is empty after a fault
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> occupancy == '0 && map_valid == '0);
  // R5: nothing retires from an empty window
  assert_retire_needs_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid != '0 |-> occupancy != '0);
endmodule

// File: tb/rob_core_tb.sv
module rob_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  alloc_num = '0;
  logic [8:0]  alloc_dst = '0;
  logic [2:0]  alloc_wen = '0;
  logic        alloc_ok;
  logic [17:0] alloc_tag;
  logic        wb_valid = 1'b0;
  logic [5:0]  wb_tag = '0;
  logic [31:0] wb_data = '0;
  logic        wb_exc = 1'b0, wb_mispred = 1'b0;
  logic [2:0]  ret_valid, clr_valid;
  logic [17:0] ret_tag;
  logic [8:0]  ret_reg, clr_reg;
  logic [95:0] ret_data;
  logic        fault_valid, fault_mispred;
  logic [5:0]  fault_tag, occupancy;
  logic [7:0]  map_valid;
  logic [47:0] map_tag;
  logic [255:0] arf_data;

  always #10 clk = ~clk;  // 50 MHz

  rob_core u_dut (.*);

  typedef struct packed { logic [5:0] tag; logic [2:0] rg; logic [31:0] d; } sb_item_t;
  sb_item_t exp_q[$];
  int checks = 0, errors = 0;
  logic [31:0] salt = 32'h0;
  bit finished = 1'b0;

  function automatic logic [31:0] dv(int t);
    return salt + 32'(t) * 32'h0001_0003;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(int t, int r, logic [31:0] d);
    exp_q.push_back({6'(t), 3'(r), d});
  endtask

  task automatic idle();
    @(negedge clk);
    alloc_num = '0; alloc_wen = '0; alloc_dst = '0;
    wb_valid = 1'b0; wb_exc = 1'b0; wb_mispred = 1'b0;
  endtask

  task automatic drive_alloc(int n, int d0, int d1, int d2, logic [2:0] w);
    idle();
    alloc_num = 2'(n);
    alloc_dst = {3'(d2), 3'(d1), 3'(d0)};
    alloc_wen = w;
  endtask

  task automatic drive_wb(int t, logic [31:0] d, bit exc, bit mis);
    idle();
    wb_valid = 1'b1; wb_tag = 6'(t); wb_data = d; wb_exc = exc; wb_mispred = mis;
  endtask

  function automatic logic [31:0] arf(int r);
    return arf_data[r*32 +: 32];
  endfunction

  // scoreboard monitor: compare each retiring lane against the expected program order
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 3; i++) begin
        if (ret_valid[i]) begin
          sb_item_t it;
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R5 unexpected retire tag actual=%0h expected=none", ret_tag[i*6 +: 6]);
          end else begin
            it = exp_q.pop_front();
            if (ret_tag[i*6 +: 6] !== it.tag || ret_data[i*32 +: 32] !== it.d ||
                ret_reg[i*3 +: 3] !== it.rg) begin
              errors++;
              $display("FAIL R5 retire lane %0d actual=%0h/%0h/%0h expected=%0h/%0h/%0h", i,
                       ret_tag[i*6 +: 6], ret_reg[i*3 +: 3], ret_data[i*32 +: 32],
                       it.tag, it.rg, it.d);
            end
          end
        end
      end
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep_r1, keep_r2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    idle(); #1;
    chk("R1", "occupancy", occupancy, 0);
    chk("R1", "map_valid", map_valid, 0);
    chk("R1", "arf", arf_data[63:0] | arf_data[255:192], 0);
    chk("R1", "alloc_tag0", alloc_tag[5:0], 0);
    chk("R1", "ret/clr/fault", {ret_valid, clr_valid, fault_valid}, 0);

    // R2/R5/R6/R7: three writers, out-of-order completion
    salt = 32'h1100_0000;
    drive_alloc(3, 1, 2, 1, 3'b111); #1;
    chk("R2", "alloc_ok", alloc_ok, 1);
    chk("R2", "tags", alloc_tag, {6'd2, 6'd1, 6'd0});
    push(0, 1, dv(0)); push(1, 2, dv(1)); push(2, 1, dv(2));
    idle(); #1;
    chk("R2", "occupancy", occupancy, 3);
    chk("R7", "map r1", {map_valid[1], map_tag[1*6 +: 6]}, {1'b1, 6'd2});
    chk("R7", "map r2", {map_valid[2], map_tag[2*6 +: 6]}, {1'b1, 6'd1});
    drive_wb(2, dv(2), 0, 0);
    drive_wb(1, dv(1), 0, 0);
    idle(); #1;
    chk("R5", "no retire before oldest done", ret_valid, 0);
    drive_wb(0, dv(0), 0, 0);
    idle(); #1;
    chk("R5", "three retire", ret_valid, 3'b111);
    chk("R7", "clear only matching", clr_valid, 3'b110);
    idle(); #1;
    keep_r1 = dv(2); keep_r2 = dv(1);
    chk("R6", "youngest kept r1", arf(1), keep_r1);
    chk("R6", "r2", arf(2), keep_r2);
    chk("R7", "maps cleared", map_valid, 0);
    chk("R5", "empty", occupancy, 0);

    // R7: a younger writer keeps its mapping
    salt = 32'h2200_0000;
    drive_alloc(1, 4, 0, 0, 3'b001); #1; chk("R2", "tag3", alloc_tag[5:0], 3);
    drive_alloc(1, 4, 0, 0, 3'b001); #1; chk("R2", "tag4", alloc_tag[5:0], 4);
    push(3, 4, dv(3)); push(4, 4, dv(4));
    drive_wb(3, dv(3), 0, 0);
    idle(); #1;
    chk("R5", "tag3 retires", ret_valid, 3'b001);
    chk("R7", "stale clear suppressed", clr_valid, 0);
    idle(); #1;
    chk("R7", "younger mapping kept", {map_valid[4], map_tag[4*6 +: 6]}, {1'b1, 6'd4});
    chk("R6", "r4 older value", arf(4), dv(3));
    drive_wb(4, dv(4), 0, 0);
    idle(); #1;
    chk("R7", "own clear", clr_valid, 3'b001);
    idle(); #1;
    chk("R7", "r4 unmapped", map_valid[4], 0);
    chk("R6", "r4 value", arf(4), dv(4));

    // R9: entry without a register write
    salt = 32'h3300_0000;
    drive_alloc(1, 1, 0, 0, 3'b000);
    push(5, 1, dv(5));
    idle(); #1;
    chk("R9", "no mapping", map_valid, 0);
    drive_wb(5, dv(5), 0, 0);
    idle(); idle(); #1;
    chk("R9", "r1 untouched", arf(1), keep_r1);

    // R2/R3: fill the window across the wrap point
    salt = 32'h4400_0000;
    for (int k = 0; k < 13; k++) begin
      int t0;
      t0 = (6 + 3 * k) % 40;
      drive_alloc(3, 3, 3, 3, 3'b111); #1;
      chk("R2", "fill ok", alloc_ok, 1);
      chk("R2", "fill tags", alloc_tag,
          {6'((t0 + 2) % 40), 6'((t0 + 1) % 40), 6'(t0)});
      for (int i = 0; i < 3; i++) push((t0 + i) % 40, 3, dv((t0 + i) % 40));
    end
    idle(); #1;
    chk("R3", "occupancy 39", occupancy, 39);
    drive_alloc(3, 3, 3, 3, 3'b111); #1;
    chk("R3", "refuse 3 with 1 free", alloc_ok, 0);
    idle(); #1;
    chk("R3", "still 39", occupancy, 39);
    drive_alloc(1, 3, 0, 0, 3'b001); #1;
    chk("R2", "last slot", {alloc_ok, alloc_tag[5:0]}, {1'b1, 6'd5});
    push(5, 3, dv(5));
    idle(); #1;
    chk("R3", "full", occupancy, 40);
    drive_alloc(1, 3, 0, 0, 3'b001); #1;
    chk("R3", "refuse when full", alloc_ok, 0);
    for (int j = 39; j >= 0; j--) drive_wb((6 + j) % 40, dv((6 + j) % 40), 0, 0);
    idle(); #1;
    chk("R5", "three per cycle", ret_valid, 3'b111);
    repeat (15) idle();
    #1;
    chk("R5", "drained", occupancy, 0);
    chk("R6", "r3 last", arf(3), dv(5));

    // R8: mispredict behind a good entry
    salt = 32'h5500_0000;
    drive_alloc(3, 5, 6, 7, 3'b111); #1;
    chk("R2", "tags after wrap", alloc_tag, {6'd8, 6'd7, 6'd6});
    push(6, 5, dv(6));
    drive_wb(7, dv(7), 0, 1);
    drive_wb(8, dv(8), 0, 0);
    drive_wb(6, dv(6), 0, 0);
    idle(); #1;
    chk("R8", "stop at faulting entry", {ret_valid, fault_valid}, {3'b001, 1'b0});
    drive_alloc(1, 0, 0, 0, 3'b001); #1;
    chk("R8", "fault report", {fault_valid, fault_tag, fault_mispred}, {1'b1, 6'd7, 1'b1});
    chk("R8", "alloc refused", alloc_ok, 0);
    idle(); #1;
    chk("R8", "flushed", occupancy, 0);
    chk("R8", "maps invalid", map_valid, 0);
    chk("R8", "tag restart", alloc_tag[5:0], 0);
    chk("R8", "fault result discarded", arf(6), 0);
    chk("R6", "pre-fault retire", arf(5), dv(6));

    // R4: writeback to a free tag, then exception fault
    salt = 32'h6600_0000;
    drive_wb(0, 32'hDEAD_BEEF, 0, 0);
    drive_alloc(1, 2, 0, 0, 3'b001);
    idle(); idle(); #1;
    chk("R4", "stray wb ignored", {ret_valid, occupancy}, {3'b000, 6'd1});
    drive_wb(0, dv(0), 1, 0);
    idle(); #1;
    chk("R8", "exception report", {fault_valid, fault_tag, fault_mispred, ret_valid},
        {1'b1, 6'd0, 1'b0, 3'b000});
    idle(); #1;
    chk("R8", "empty after exc", occupancy, 0);
    chk("R8", "r2 untouched", arf(2), keep_r2);

    chk("R5", "scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule